// File: doc/BRIEF.md
# DAC Channel Bank Serial Write Receiver

This block is a two-wire serial slave that only receives. It turns bus writes into register updates for a bank of 40 channels, each 12 bits wide. SCL and SDA enter the block asynchronously. The block synchronizes and oversamples them in its own clock domain. It recognises START and STOP conditions and compares the address byte against a fixed prefix plus two strapped address bits. It pulls SDA low in the ninth clock of each byte it accepts. The result of each complete write appears on a write port as a channel number, a 2-bit register select and a 12-bit value.

After the address byte, the next byte is a pointer. A pointer equal to 0xFF starts a burst. The channel starts at 0, and every pair of data bytes loads the current channel and then moves to the next one. After channel 39 the block returns on its own to the ordinary form. In the ordinary form the low six bits of a pointer name the channel, and two data bytes follow it. Within one transaction, the byte that follows a completed ordinary write is taken as a new pointer. A STOP at any moment ends the transaction, ends a burst and discards half-received data.

The write port is a single-cycle valid strobe with no ready signal. The bus cannot be held off because the block does no clock stretching, so there is no back-pressure. The sink must take every strobe in the cycle it appears. Two strobes are always separated by at least one full byte time on the bus.

Top module: `dacbank_serial_wr`

## Requirements
- R1: An address byte is accepted only when bits [7:3] are 10101, bits [2:1] equal `dev_addr_i` and bit [0] (direction) is 0. Any other address byte is not acknowledged, and the block ignores all bytes until the next START.
- R2: For every accepted byte the block drives `sda_pull_o` high during the ninth SCL clock. It keeps `sda_pull_o` low at all other times and for bytes it does not accept.
- R3: In the ordinary form the pointer's bits [5:0] give the channel, and two data bytes follow. Pointer and data bytes are always acknowledged, but a channel number above 39 produces no write.
- R4: In the first data byte, bits [7:6] are the register select and bits [5:0] are value bits 11..6. In the second data byte, bits [7:2] are value bits 5..0, and bits [1:0] are ignored.
- R5: A pointer of 0xFF starts a burst at channel 0. Each following pair of data bytes writes the current channel, and the channel then advances by one.
- R6: After the burst writes channel 39, the block returns to the ordinary form, and the next byte of the same transaction is taken as a pointer.
- R7: A STOP ends any burst and discards a partly received data pair. A new transaction after it starts from the address byte.
- R8: Each write appears as exactly one cycle of `wr_valid_o` with channel, select and value. It follows the end of the ninth clock of the second data byte. There is no back-pressure.
- R9: After an ordinary write, the next byte in the same transaction is a new pointer. A repeated START restarts at the address byte and discards partial data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| dev_addr_i | input | 2 | Strapped address bits compared with address bits [2:1] |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_chan_o | output | 6 | Channel being written |
| wr_sel_o | output | 2 | Register select from the first data byte |
| wr_data_o | output | 12 | 12-bit value |

## Verification
The bench runs a full 40-channel burst and then sends an ordinary pointer in the same transaction. A block that fails to fall back would write to channel 40 or would read the pointer as data. It stops a burst between the two bytes of a pair and then writes another channel. A block that kept the half pair or the burst state would write a stale value or the wrong channel. It uses a mismatched strap, a wrong fixed prefix, the read direction and an out-of-range channel. A faulty block would acknowledge, or would produce a write, where neither may happen. A repeated START in the middle of a pair checks that the partial data is thrown away.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam logic [4:0] ADDR_PREFIX = 5'b10101;
  localparam logic [7:0] BURST_PTR   = 8'hFF;
  localparam int         PTR_W       = 6;
  localparam int         SEL_W       = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_PTR, S_MSB, S_LSB, S_COMMIT, S_IGNORE
  } frame_st_t;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/byte_link.sv
module byte_link #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              ack_en_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_done_o,
  output logic              sda_pull_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic              active_q, in_ack_q, ack_drive_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
    end else if (start_i) begin
      active_q    <= 1'b1;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
      bitcnt_q    <= '0;
    end else if (stop_i) begin
      active_q    <= 1'b0;
      in_ack_q    <= 1'b0;
      ack_drive_q <= 1'b0;
    end else if (active_q) begin
      if (scl_rise_i && bitcnt_q < FULL) begin
        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_i};
        bitcnt_q <= bitcnt_q + CNT_W'(1);
      end
      if (scl_fall_i) begin
        if (in_ack_q) begin
          in_ack_q    <= 1'b0;
          ack_drive_q <= 1'b0;
          bitcnt_q    <= '0;
          if (!ack_drive_q) active_q <= 1'b0;
        end else if (bitcnt_q == FULL) begin
          in_ack_q    <= 1'b1;
          ack_drive_q <= ack_en_i;
        end
      end
    end
  end

  assign byte_valid_o = active_q && scl_fall_i && !in_ack_q && bitcnt_q == FULL;
  assign ack_done_o   = active_q && scl_fall_i && in_ack_q;
  assign byte_o       = shreg_q;
  assign sda_pull_o   = ack_drive_q;

  // R2: acknowledge only starts right after a received byte
  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive_q) |-> $past(byte_valid_o));

  // R1: an unacknowledged byte puts the link to sleep until START
  a_r1_sleep_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done_o && !ack_drive_q && !start_i && !stop_i) |=> !active_q);
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import dacbank_pkg::*;
#(
  parameter int NCH  = 40,
  parameter int DW   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             ack_done_i,
  input  logic [1:0]       dev_addr_i,
  output logic             ack_en_o,
  output logic             wr_valid_o,
  output logic [PTR_W-1:0] wr_chan_o,
  output logic [SEL_W-1:0] wr_sel_o,
  output logic [DW-1:0]    wr_data_o
);
  localparam int HI_W = 8 - SEL_W;
  localparam int LO_W = DW - HI_W;
  localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NCH - 1);

  frame_st_t        state_q;
  logic             burst_q;
  logic [PTR_W-1:0] chan_q;
  logic [SEL_W-1:0] sel_q;
  logic [HI_W-1:0]  hi_q;
  logic [LO_W-1:0]  lo_q;
  logic             addr_match;

  assign addr_match = byte_i[7:3] == ADDR_PREFIX && byte_i[2:1] == dev_addr_i && !byte_i[0];

  always_comb begin
    case (state_q)
      S_ADDR:              ack_en_o = addr_match;
      S_PTR, S_MSB, S_LSB: ack_en_o = 1'b1;
      default:             ack_en_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      burst_q    <= 1'b0;
      chan_q     <= '0;
      sel_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      wr_valid_o <= 1'b0;
      wr_chan_o  <= '0;
      wr_sel_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        state_q <= S_ADDR;
        burst_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= S_IDLE;
        burst_q <= 1'b0;
      end else begin
        if (byte_valid_i) begin
          case (state_q)
            S_ADDR: state_q <= addr_match ? S_PTR : S_IGNORE;
            S_PTR: begin
              burst_q <= byte_i == BURST_PTR;
              chan_q  <= (byte_i == BURST_PTR) ? '0 : byte_i[PTR_W-1:0];
              state_q <= S_MSB;
            end
            S_MSB: begin
              sel_q   <= byte_i[7 -: SEL_W];
              hi_q    <= byte_i[HI_W-1:0];
              state_q <= S_LSB;
            end
            S_LSB: begin
              lo_q    <= byte_i[7 -: LO_W];
              state_q <= S_COMMIT;
            end
            default: ;
          endcase
        end
        if (ack_done_i && state_q == S_COMMIT) begin
          if (chan_q < PTR_W'(NCH)) begin
            wr_valid_o <= 1'b1;
            wr_chan_o  <= chan_q;
            wr_sel_o   <= sel_q;
            wr_data_o  <= {hi_q, lo_q};
          end
          if (burst_q && chan_q != LAST_CH) begin
            chan_q  <= chan_q + PTR_W'(1);
            state_q <= S_MSB;
          end else begin
            burst_q <= 1'b0;
            state_q <= S_PTR;
          end
        end
      end
    end
  end

  a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_chan_o < PTR_W'(NCH));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  a_r7_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!burst_q && state_q == S_IDLE));

  a_r5_burst_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && state_q == S_PTR && byte_i == BURST_PTR && !start_i && !stop_i)
      |=> (burst_q && chan_q == '0));

  a_r6_burst_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done_i && state_q == S_COMMIT && burst_q && chan_q == LAST_CH && !start_i && !stop_i)
      |=> (!burst_q && state_q == S_PTR));
endmodule

// File: rtl/dacbank_serial_wr.sv
module dacbank_serial_wr
  import dacbank_pkg::*;
#(
  parameter int NCH = 40,
  parameter int DW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       dev_addr_i,
  output logic             sda_pull_o,
  output logic             wr_valid_o,
  output logic [PTR_W-1:0] wr_chan_o,
  output logic [SEL_W-1:0] wr_sel_o,
  output logic [DW-1:0]    wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic byte_valid, ack_done, ack_en;
  logic [7:0] rx_byte;

  bus_sampler #(.SYNC_STAGES(2)) sampler_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  byte_link #(.BYTE_W(8)) link_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_c), .stop_i(stop_c),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .ack_en_i(ack_en), .byte_valid_o(byte_valid), .byte_o(rx_byte),
    .ack_done_o(ack_done), .sda_pull_o(sda_pull_o)
  );

  frame_ctrl #(.NCH(NCH), .DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_c), .stop_i(stop_c),
    .byte_valid_i(byte_valid), .byte_i(rx_byte), .ack_done_i(ack_done),
    .dev_addr_i(dev_addr_i), .ack_en_o(ack_en), .wr_valid_o(wr_valid_o),
    .wr_chan_o(wr_chan_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o)
  );
endmodule

// File: tb/dacbank_serial_wr_tb.sv
module dacbank_serial_wr_tb_top;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic sda_pull, wr_valid;
  logic [5:0] wr_chan;
  logic [1:0] wr_sel;
  logic [11:0] wr_data;
  logic sda_line;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [19:0] expq[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  dacbank_serial_wr dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_addr_i(dev_addr), .sda_pull_o(sda_pull), .wr_valid_o(wr_valid),
    .wr_chan_o(wr_chan), .wr_sel_o(wr_sel), .wr_data_o(wr_data)
  );

  localparam logic [7:0] ADDR_OK = 8'hAC; // 10101,10,0

  task automatic pause(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; pause(Q); scl_m = 1'b1; pause(Q);
    sda_m = 1'b0; pause(Q); scl_m = 1'b0; pause(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; pause(Q); scl_m = 1'b1; pause(Q);
    sda_m = 1'b1; pause(2 * Q);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; pause(Q); scl_m = 1'b1; pause(2 * Q); scl_m = 1'b0; pause(Q);
    end
    sda_m = 1'b1; pause(Q); scl_m = 1'b1; pause(Q);
    @(negedge clk); got = sda_pull;
    check(got == exp_ack, req, int'(got), int'(exp_ack));
    pause(Q); scl_m = 1'b0; pause(Q);
  endtask

  function automatic logic [11:0] val_of(int ch);
    return 12'h5A3 ^ 12'(ch * 37);
  endfunction

  // R4: byte 1 = {sel, d[11:6]}, byte 2 = {d[5:0], xx}
  task automatic send_pair(int ch, logic [1:0] sel, logic [11:0] d, bit expect_wr, string req);
    if (expect_wr) expq.push_back({6'(ch), sel, d});
    send_byte({sel, d[11:6]}, 1'b1, req);
    send_byte({d[5:0], 2'b11}, 1'b1, req);
  endtask

  // R8 scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected write", int'({wr_chan, wr_sel, wr_data}), 0);
      end else begin
        logic [19:0] e;
        e = expq.pop_front();
        check({wr_chan, wr_sel, wr_data} == e, "R4 R8 write", int'({wr_chan, wr_sel, wr_data}), int'(e));
      end
    end
  end

  task automatic drain(string req);
    pause(40);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    pause(4);
    @(negedge clk);
    check(wr_valid == 1'b0 && sda_pull == 1'b0, "R8 reset", int'({wr_valid, sda_pull}), 0);
    rst_n = 1'b1;
    pause(10);

    // R3 / R9: ordinary write, then a second pointer in the same transaction
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R1 addr");
    send_byte(8'h05, 1'b1, "R3 ptr");
    send_pair(5, 2'b11, 12'hABC, 1'b1, "R3 data");
    send_byte(8'h27, 1'b1, "R9 ptr2");
    send_pair(39, 2'b01, 12'h00F, 1'b1, "R9 data");
    bus_stop();
    drain("R9 writes done");

    // R1: wrong strap, wrong prefix, read direction
    bus_start();
    send_byte(8'hAE, 1'b0, "R1 strap mismatch");
    send_byte(8'h01, 1'b0, "R1 ignored ptr");
    send_byte(8'h12, 1'b0, "R1 ignored data");
    bus_stop();
    bus_start();
    send_byte(8'h2C, 1'b0, "R1 prefix mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hAD, 1'b0, "R1 read direction");
    send_byte(8'h02, 1'b0, "R2 no ack while ignoring");
    bus_stop();
    drain("R1 no write");

    // R3: channel above 39 acked, not written
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R3 addr");
    send_byte(8'h2D, 1'b1, "R3 ptr 45");
    send_pair(45, 2'b00, 12'h777, 1'b0, "R3 data 45");
    bus_stop();
    drain("R3 out of range");

    // R5 / R6: full burst then fall back
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R5 addr");
    send_byte(8'hFF, 1'b1, "R5 burst ptr");
    for (int ch = 0; ch < 40; ch++) send_pair(ch, 2'(ch), val_of(ch), 1'b1, "R5 burst");
    send_byte(8'h07, 1'b1, "R6 pointer after burst");
    send_pair(7, 2'b10, 12'h3C5, 1'b1, "R6 data");
    bus_stop();
    drain("R6 burst done");

    // R7: STOP mid pair
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R7 addr");
    send_byte(8'hFF, 1'b1, "R7 burst");
    send_pair(0, 2'b01, 12'h111, 1'b1, "R7 ch0");
    send_pair(1, 2'b01, 12'h222, 1'b1, "R7 ch1");
    send_byte(8'hBF, 1'b1, "R7 half pair");
    bus_stop();
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R7 addr2");
    send_byte(8'h02, 1'b1, "R7 ptr2");
    send_pair(2, 2'b00, 12'h0A5, 1'b1, "R7 fresh");
    bus_stop();
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R7 addr3");
    send_byte(8'hFF, 1'b1, "R7 burst restart");
    send_pair(0, 2'b11, 12'hFED, 1'b1, "R7 ch0 again");
    bus_stop();
    drain("R7 writes done");

    // R9: repeated START discards partial data
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R9 addr");
    send_byte(8'h03, 1'b1, "R9 ptr3");
    send_byte(8'hFF, 1'b1, "R9 half");
    bus_start();
    send_byte(ADDR_OK, 1'b1, "R9 addr again");
    send_byte(8'h04, 1'b1, "R9 ptr4");
    send_pair(4, 2'b10, 12'h5C3, 1'b1, "R9 ch4");
    bus_stop();
    drain("R9 restart done");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule